// File: doc/BRIEF.md
# Keyboard-Controller Host Mailbox Channel

This block is a one-byte mailbox in each direction between an external host processor and a local slave processor. The host reaches it through an asynchronous strobe interface: an active-low chip select, active-low read and write strobes, one address line and an 8-bit data bus. The slave reaches it through a small synchronous register bus. The block synchronises the host strobes into the slave clock domain and acts on the rising edge of each strobe.

When the host writes, the byte goes into an inbound register and the address line is recorded as a command/data marker. When the slave writes, the byte goes into an outbound register that the host can read. Full flags report whether each direction holds an unconsumed byte. A status byte is returned to the host when the address line is high.

The block also drives an A20 gate output. With the hardware path disabled, the slave sets that output directly. With the hardware path enabled, the host opens a gate-update sequence by writing command byte 0xD1. The data byte that follows then sets the gate with no help from the slave.

Top module: `kbc_host_mailbox`

## Requirements
- R1: A host write (hcs_n low while hwr_n rises) stores hdata_in in the inbound register. The slave reads that register at s_addr 0.
- R2: On each host write, the level of ha0 is stored as the command/data flag in bit 3 of the status byte (1 = command).
- R3: A host write sets the inbound-full flag (status bit 1). A slave read at s_addr 0 clears it. If both happen in the same cycle, the host write wins.
- R4: A slave write at s_addr 1 loads the outbound register, which the slave reads back at s_addr 1. The write also sets the outbound-full flag (status bit 0).
- R5: While hcs_n, hrd_n and ha0 are all low, hdata_out carries the outbound register and hdata_oe is high. The outbound-full flag clears once that read's strobe rises.
- R6: A host read with ha0 high returns the status byte: bit 0 outbound-full, bit 1 inbound-full, bit 3 command/data, and all other bits 0. The slave reads the same byte at s_addr 2.
- R7: hdata_oe is low whenever hcs_n or hrd_n is high. A write strobe while hcs_n is high changes nothing.
- R8: The control register sits at s_addr 3. Bit 0 enables the hardware A20 path and bit 1 is the slave-driven A20 level. While bit 0 is 0, gate_a20 equals bit 1, and host command/data sequences do not affect it.
- R9: While the hardware path is enabled, a host command write of 0xD1 followed by a host data write sets gate_a20 to bit 1 of that data byte. A data write not preceded by 0xD1 leaves gate_a20 unchanged. Any other command byte cancels a pending 0xD1.
- R10: After reset, both full flags, the command/data flag, the control register and gate_a20 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hcs_n | input | 1 | Host chip select, active low |
| hrd_n | input | 1 | Host read strobe, active low |
| hwr_n | input | 1 | Host write strobe, active low |
| ha0 | input | 1 | Host address line: 0 selects data, 1 selects command/status |
| hdata_in | input | DW | Host write data |
| hdata_out | output | DW | Host read data |
| hdata_oe | output | 1 | Output enable for the host data bus |
| s_sel | input | 1 | Slave bus access strobe |
| s_wr | input | 1 | Slave bus write (1) or read (0) |
| s_addr | input | 2 | Slave register address |
| s_wdata | input | DW | Slave write data |
| s_rdata | output | DW | Slave read data, combinational |
| gate_a20 | output | 1 | A20 gate output |

## Verification
A host strobe passes through two synchroniser stages. Registers therefore change on the second clock edge after hwr_n or hrd_n rises. The bench waits three falling edges after each strobe before it samples anything that depends on it. Host read data and hdata_oe are combinational from the pins, so they are checked one falling edge after the strobe falls. Slave reads are combinational and are sampled shortly after the slave drives its bus. Flag clears caused by a slave access are checked one edge later.

// File: rtl/kbc_host_mailbox.sv
module kbc_host_mailbox #(
  parameter int          DW      = 8,
  parameter logic [7:0]  A20_CMD = 8'hD1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hcs_n,
  input  logic          hrd_n,
  input  logic          hwr_n,
  input  logic          ha0,
  input  logic [DW-1:0] hdata_in,
  output logic [DW-1:0] hdata_out,
  output logic          hdata_oe,
  input  logic          s_sel,
  input  logic          s_wr,
  input  logic [1:0]    s_addr,
  input  logic [DW-1:0] s_wdata,
  output logic [DW-1:0] s_rdata,
  output logic          gate_a20
);

  logic          cs1, cs2, wr1, wr2, rd1, rd2, a01, a02;
  logic [DW-1:0] d1, d2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cs1, cs2, wr1, wr2, rd1, rd2} <= '1;
      {a01, a02} <= '0;
      d1 <= '0;
      d2 <= '0;
    end else begin
      cs1 <= hcs_n;  cs2 <= cs1;
      wr1 <= hwr_n;  wr2 <= wr1;
      rd1 <= hrd_n;  rd2 <= rd1;
      a01 <= ha0;    a02 <= a01;
      d1  <= hdata_in;
      d2  <= d1;
    end
  end

  logic wr_evt, rd_evt;
  assign wr_evt = !cs2 && !wr2 && wr1;
  assign rd_evt = !cs2 && !rd2 && rd1 && !a02;

  logic s_rd_idr, s_wr_odr, s_wr_ctl;
  assign s_rd_idr = s_sel && !s_wr && (s_addr == 2'd0);
  assign s_wr_odr = s_sel &&  s_wr && (s_addr == 2'd1);
  assign s_wr_ctl = s_sel &&  s_wr && (s_addr == 2'd3);

  logic [DW-1:0] idr, odr;
  logic          ibf, obf, cd;
  logic          fast_en, port_a20, fast_a20, cmd_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idr <= '0;
      odr <= '0;
      ibf <= 1'b0;
      obf <= 1'b0;
      cd  <= 1'b0;
    end else begin
      if (wr_evt) begin
        idr <= d2;
        cd  <= a02;
      end
      if (wr_evt)        ibf <= 1'b1;
      else if (s_rd_idr) ibf <= 1'b0;
      if (s_wr_odr) begin
        odr <= s_wdata;
        obf <= 1'b1;
      end else if (rd_evt) begin
        obf <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_en  <= 1'b0;
      port_a20 <= 1'b0;
      fast_a20 <= 1'b0;
      cmd_pend <= 1'b0;
    end else begin
      if (s_wr_ctl) begin
        fast_en  <= s_wdata[0];
        port_a20 <= s_wdata[1];
      end
      if (!fast_en) begin
        cmd_pend <= 1'b0;
      end else if (wr_evt) begin
        if (a02) begin
          cmd_pend <= (d2[7:0] == A20_CMD);
        end else begin
          if (cmd_pend) fast_a20 <= d2[1];
          cmd_pend <= 1'b0;
        end
      end
    end
  end

  logic [DW-1:0] status;
  assign status = DW'({cd, 1'b0, ibf, obf});

  assign hdata_oe  = !hcs_n && !hrd_n;
  assign hdata_out = ha0 ? status : odr;
  assign gate_a20  = fast_en ? fast_a20 : port_a20;

  always_comb begin
    case (s_addr)
      2'd0:    s_rdata = idr;
      2'd1:    s_rdata = odr;
      2'd2:    s_rdata = status;
      default: s_rdata = DW'({port_a20, fast_en});
    endcase
  end

endmodule

module kbc_host_mailbox_chk #(parameter int DW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_evt,
  input logic          rd_evt,
  input logic          a02,
  input logic [DW-1:0] d2,
  input logic          s_rd_idr,
  input logic          s_wr_odr,
  input logic          s_wr_ctl,
  input logic [DW-1:0] s_wdata,
  input logic          ibf,
  input logic          obf,
  input logic          cd,
  input logic [DW-1:0] idr,
  input logic [DW-1:0] odr,
  input logic          fast_en,
  input logic          gate_a20
);
  p_idr_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> idr == $past(d2));
  p_cd_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> cd == $past(a02));
  p_ibf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> ibf);
  p_ibf_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rd_idr && !wr_evt) |=> !ibf);
  p_obf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    s_wr_odr |=> (obf && odr == $past(s_wdata)));
  p_obf_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !s_wr_odr) |=> !obf);
  p_a20_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_en && !wr_evt && !s_wr_ctl) |=> $stable(gate_a20));
endmodule

bind kbc_host_mailbox kbc_host_mailbox_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .rd_evt(rd_evt), .a02(a02),
  .d2(d2), .s_rd_idr(s_rd_idr), .s_wr_odr(s_wr_odr), .s_wr_ctl(s_wr_ctl),
  .s_wdata(s_wdata), .ibf(ibf), .obf(obf), .cd(cd), .idr(idr), .odr(odr),
  .fast_en(fast_en), .gate_a20(gate_a20)
);

// File: tb/tb_kbc_host_mailbox.sv
module tb_kbc_host_mailbox;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic hcs_n = 1, hrd_n = 1, hwr_n = 1, ha0 = 0;
  logic [7:0] hdata_in = 0, hdata_out, s_wdata = 0, s_rdata;
  logic hdata_oe, s_sel = 0, s_wr = 0, gate_a20;
  logic [1:0] s_addr = 0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbc_host_mailbox dut (
    .clk(clk), .rst_n(rst_n), .hcs_n(hcs_n), .hrd_n(hrd_n), .hwr_n(hwr_n),
    .ha0(ha0), .hdata_in(hdata_in), .hdata_out(hdata_out), .hdata_oe(hdata_oe),
    .s_sel(s_sel), .s_wr(s_wr), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_rdata(s_rdata), .gate_a20(gate_a20)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic host_write(input logic a0, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    hcs_n = !sel; ha0 = a0; hdata_in = d; hwr_n = 0;
    wait_n(3);
    hwr_n = 1;
    wait_n(3);
    hcs_n = 1;
  endtask

  task automatic host_read(input logic a0, output logic [7:0] d, output logic oe);
    @(negedge clk);
    hcs_n = 0; ha0 = a0; hrd_n = 0;
    @(negedge clk);
    d = hdata_out; oe = hdata_oe;
    hrd_n = 1;
    wait_n(3);
    hcs_n = 1;
  endtask

  task automatic slave_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    s_sel = 1; s_wr = 1; s_addr = a; s_wdata = d;
    @(negedge clk);
    s_sel = 0; s_wr = 0;
  endtask

  task automatic slave_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    s_sel = 1; s_wr = 0; s_addr = a;
    #1 d = s_rdata;
    @(negedge clk);
    s_sel = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    slave_read(2'd2, v); chk("R10 status", v, 8'h00);
    slave_read(2'd3, v); chk("R10 ctrl", v, 8'h00);
    chk("R10 gate", {7'b0, gate_a20}, 8'h00);
  endtask

  task automatic t_host_to_slave();
    logic [7:0] v; logic oe;
    host_write(1'b0, 8'h5A);
    host_read(1'b1, v, oe); chk("R6 status after data write", v, 8'h02);
    slave_read(2'd0, v); chk("R1 idr data", v, 8'h5A);
    slave_read(2'd2, v); chk("R3 ibf cleared", v, 8'h00);
    host_write(1'b1, 8'hC3);
    slave_read(2'd2, v); chk("R2 cd set by command", v, 8'h0A);
    slave_read(2'd0, v); chk("R1 idr command", v, 8'hC3);
    host_write(1'b0, 8'h11);
    slave_read(2'd2, v); chk("R2 cd cleared by data", v, 8'h02);
    slave_read(2'd0, v);
  endtask

  task automatic t_slave_to_host();
    logic [7:0] v; logic oe;
    slave_write(2'd1, 8'hA7);
    slave_read(2'd1, v); chk("R4 odr readback", v, 8'hA7);
    host_read(1'b1, v, oe); chk("R6 status obf", v, 8'h01);
    chk("R7 oe on status read", {7'b0, oe}, 8'h01);
    host_read(1'b0, v, oe); chk("R5 host reads odr", v, 8'hA7);
    chk("R5 oe on data read", {7'b0, oe}, 8'h01);
    slave_read(2'd2, v); chk("R5 obf cleared", v, 8'h00);
  endtask

  task automatic t_ignored();
    logic [7:0] v;
    @(negedge clk); hcs_n = 1; hrd_n = 0;
    #1 chk("R7 oe low cs high", {7'b0, hdata_oe}, 8'h00);
    hrd_n = 1; hcs_n = 0;
    #1 chk("R7 oe low rd high", {7'b0, hdata_oe}, 8'h00);
    hcs_n = 1;
    host_write(1'b0, 8'hEE, 1'b0);
    slave_read(2'd2, v); chk("R7 deselected write no ibf", v, 8'h00);
    slave_read(2'd0, v); chk("R7 deselected write idr kept", v, 8'h11);
  endtask

  task automatic t_a20_port();
    logic [7:0] v;
    slave_write(2'd3, 8'h02);
    chk("R8 port a20 high", {7'b0, gate_a20}, 8'h01);
    host_write(1'b1, 8'hD1); host_write(1'b0, 8'h00);
    chk("R8 sequence ignored when disabled", {7'b0, gate_a20}, 8'h01);
    slave_write(2'd3, 8'h00);
    chk("R8 port a20 low", {7'b0, gate_a20}, 8'h00);
    slave_read(2'd0, v);
  endtask

  task automatic t_a20_fast();
    logic [7:0] v;
    slave_write(2'd3, 8'h01);
    host_write(1'b1, 8'hD1); host_write(1'b0, 8'h02);
    chk("R9 fast a20 set", {7'b0, gate_a20}, 8'h01);
    host_write(1'b0, 8'h00);
    chk("R9 data without cmd no effect", {7'b0, gate_a20}, 8'h01);
    host_write(1'b1, 8'hD1); host_write(1'b1, 8'hFF); host_write(1'b0, 8'h00);
    chk("R9 other cmd cancels", {7'b0, gate_a20}, 8'h01);
    host_write(1'b1, 8'hD1); host_write(1'b0, 8'h00);
    chk("R9 fast a20 clear", {7'b0, gate_a20}, 8'h00);
    slave_read(2'd0, v);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1;
    wait_n(2);
    t_reset();
    t_host_to_slave();
    t_slave_to_host();
    t_ignored();
    t_a20_port();
    t_a20_fast();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule